// File: doc/BRIEF.md
# Key-Protected Configuration Register Unit

This unit is a small system-configuration register file. Two of its registers hold settings that must not change by accident: a device-configuration word and an auxiliary configuration word. Both are driven straight out to the rest of the chip. Neither can be changed by an ordinary bus write.

To change a protected register, software first writes the unlock key to a dedicated lock register. The very next bus write may then land in a protected register. The unlock is one-shot: any write other than the key write drops it again, whether or not that write reached a protected register. A protected write made without the unlock is dropped and sets a sticky error flag.

Reads are always allowed and never affect the unlock. Software can therefore update the device-configuration word by read-modify-write: read the word, write the key, then write the modified value.

Top module: `keyed_cfg_regs`

## Requirements
- R1: After a synchronous active-low reset, the unlock is disarmed and the error flag is 0. The device-configuration output holds CFG_RST and the auxiliary output holds AUX_RST. `rd_valid` is 0.
- R2: A write of the key (default 0xAA, compared over the whole data word) to address 0 arms the unlock. A read of address 0 returns 1 while the unlock is armed and 0 otherwise.
- R3: A write to address 0 of any value other than the key leaves the unlock disarmed, including when it was armed before.
- R4: While the unlock is armed, a write to address 1 (device configuration) or address 2 (auxiliary) stores the write data. The matching output shows the new value in the cycle after the write.
- R5: Every bus write except a key write to address 0 disarms the unlock. This includes writes to the protected registers, to the status register and to unmapped addresses.
- R6: A write to address 1 or 2 while the unlock is disarmed leaves that register unchanged. It sets the error flag, which appears on `prot_err` and as bit 0 of address 3.
- R7: The error flag stays set until a write to address 3 with data bit 0 equal to 1. A write to address 3 with bit 0 equal to 0 leaves the flag unchanged.
- R8: A read returns data one cycle after `rd_en`, with `rd_valid` high in that cycle. Reads never change the unlock, so a read between the key write and the protected write does not disarm it. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | High in the cycle rdata carries a read result |
| dev_cfg_o | output | DATA_W | Device-configuration word |
| aux_cfg_o | output | DATA_W | Auxiliary configuration word |
| prot_err | output | 1 | Sticky flag for a refused protected write |

## Verification
Each result has a fixed delay. The unlock state, the protected register outputs and the error flag change at the clock edge that takes a write, so they are due one cycle after the write is presented. Read data and `rd_valid` come from one register stage, so they are due one cycle after `rd_en`. The bench drives each operation on a falling edge and holds it across exactly one rising edge. It samples outputs on the next falling edge and compares them with a reference model that it updates from the requirements. Every operation is separated by an idle cycle, so a stale read result or a lingering unlock shows up at the next sample.

// File: rtl/keyed_cfg_pkg.sv
// Package: shared register offsets and the address-select type for the
// key-protected configuration register unit.
// Assumes the protected registers sit at consecutive offsets from PROT_BASE.
package keyed_cfg_pkg;
    localparam int LOCK_OFS  = 0;
    localparam int PROT_BASE = 1;
    localparam int NUM_PROT  = 2;
    localparam int STAT_OFS  = PROT_BASE + NUM_PROT;

    // Index of each protected register inside the bank
    localparam int IDX_DEVCFG = 0;
    localparam int IDX_AUX    = 1;

    typedef struct packed {
        logic                lock;
        logic                stat;
        logic [NUM_PROT-1:0] prot;
    } sel_t;
endpackage

// File: rtl/keyed_cfg_decode.sv
// Module: address decoder. Turns the bus address into one-hot selects
// for the lock, status and protected registers.
// Assumes: at most one select is high; unmapped addresses select nothing.
module keyed_cfg_decode
    import keyed_cfg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    // Compare the address with each fixed offset
    always_comb begin
        sel.lock = (addr == ADDR_W'(LOCK_OFS));
        sel.stat = (addr == ADDR_W'(STAT_OFS));
        for (int i = 0; i < NUM_PROT; i++) begin
            sel.prot[i] = (addr == ADDR_W'(PROT_BASE + i));
        end
    end

    // Decode must never select two registers at once
    always_comb begin
        if (!$isunknown(addr)) begin
            p_sel_onehot_r8: assert ($onehot0(sel));
        end
    end
endmodule

// File: rtl/keyed_cfg_lock.sv
// Module: one-shot unlock and sticky protection-error flag.
// The unlock is armed by a key write to the lock register and dropped by
// any other write. The error flag is set when a protected register is
// written while the unlock is disarmed, and is cleared by writing 1 to
// bit 0 of the status register.
// Assumes: one bus write per cycle; reads do not reach this module.
module keyed_cfg_lock
    import keyed_cfg_pkg::*;
#(
    parameter int               DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY   = DATA_W'('hAA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              armed,
    output logic              err
);
    logic key_wr;
    logic prot_wr;
    logic clr_wr;

    // Classify the current write
    always_comb begin
        key_wr  = wr_en && sel.lock && (wdata == KEY);
        prot_wr = wr_en && (|sel.prot);
        clr_wr  = wr_en && sel.stat && wdata[0];
    end

    // Arm on the key write; any other write disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (wr_en) begin
            armed <= key_wr;
        end
    end

    // Sticky flag for refused protected writes, write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (prot_wr && !armed) begin
            err <= 1'b1;
        end else if (clr_wr) begin
            err <= 1'b0;
        end
    end

    // A cycle without a write leaves the unlock as it was
    p_read_keeps_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(armed));

    // Any write to a protected register consumes or refuses the unlock
    p_prot_wr_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> !armed);

    // A refused protected write raises the error flag
    p_refused_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !armed) |=> err);

    // The error flag only falls through a clearing status write
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_wr) |=> err);
endmodule

// File: rtl/keyed_cfg_bank.sv
// Module: bank of protected configuration registers.
// Each register takes write data only when it is addressed and the
// unlock is armed. The stored values drive the configuration outputs.
// Assumes: the armed input reflects the state before the current write.
module keyed_cfg_bank
    import keyed_cfg_pkg::*;
#(
    parameter int                                DATA_W   = 32,
    parameter logic [NUM_PROT-1:0][DATA_W-1:0]   RST_VALS = '0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [NUM_PROT-1:0]               sel_prot,
    input  logic                              armed,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_PROT-1:0][DATA_W-1:0]   q
);
    for (genvar g = 0; g < NUM_PROT; g++) begin : g_reg
        logic take;

        // Accept a write only through the armed unlock
        always_comb take = wr_en && sel_prot[g] && armed;

        // Storage for one protected register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= RST_VALS[g];
            end else if (take) begin
                q[g] <= wdata;
            end
        end

        // An unarmed write must not touch the register
        p_unarmed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel_prot[g] && !armed) |=> $stable(q[g]));

        // An armed write lands one cycle later
        p_armed_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && sel_prot[g] && armed) |=> (q[g] == $past(wdata)));
    end
endmodule

// File: rtl/keyed_cfg_rdmux.sv
// Module: registered read port. Selects the addressed register and
// presents it one cycle after the read strobe, with a valid pulse.
// Assumes: lock and status reads return the state before any write made
// in the same cycle.
module keyed_cfg_rdmux
    import keyed_cfg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  sel_t                            sel,
    input  logic                            armed,
    input  logic                            err,
    input  logic [NUM_PROT-1:0][DATA_W-1:0] q,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rd_valid
);
    logic [DATA_W-1:0] mux;

    // Pick the addressed register; unmapped addresses give zero
    always_comb begin
        mux = '0;
        if (sel.lock) mux = DATA_W'(armed);
        if (sel.stat) mux = DATA_W'(err);
        for (int i = 0; i < NUM_PROT; i++) begin
            if (sel.prot[i]) mux = q[i];
        end
    end

    // Register the read result and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= mux;
        end
    end

    // Read data holds while no read is issued
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // Every read strobe produces a valid pulse one cycle later
    p_rd_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: rtl/keyed_cfg_regs.sv
// Module: top of the key-protected configuration register unit.
// Ties together the decoder, the one-shot unlock, the protected register
// bank and the read port. Map: 0 lock/unlock, 1 device configuration,
// 2 auxiliary configuration, 3 status (bit 0 sticky error, write 1 clears).
// Assumes: a single bus master issuing at most one write per cycle.
module keyed_cfg_regs
    import keyed_cfg_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                ADDR_W  = 4,
    parameter logic [DATA_W-1:0] KEY     = DATA_W'('hAA),
    parameter logic [DATA_W-1:0] CFG_RST = '0,
    parameter logic [DATA_W-1:0] AUX_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] dev_cfg_o,
    output logic [DATA_W-1:0] aux_cfg_o,
    output logic              prot_err
);
    localparam logic [NUM_PROT-1:0][DATA_W-1:0] RST_VALS = {AUX_RST, CFG_RST};

    sel_t                            sel;
    logic                            armed;
    logic                            err;
    logic [NUM_PROT-1:0][DATA_W-1:0] q;

    keyed_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    keyed_cfg_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wdata),
        .armed (armed),
        .err   (err)
    );

    keyed_cfg_bank #(.DATA_W(DATA_W), .RST_VALS(RST_VALS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_prot (sel.prot),
        .armed    (armed),
        .wdata    (wdata),
        .q        (q)
    );

    keyed_cfg_rdmux #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .armed    (armed),
        .err      (err),
        .q        (q),
        .rdata    (rdata),
        .rd_valid (rd_valid)
    );

    // Drive the stored configuration out to the system
    always_comb begin
        dev_cfg_o = q[IDX_DEVCFG];
        aux_cfg_o = q[IDX_AUX];
        prot_err  = err;
    end

    // The first cycle out of reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!armed && !err && !rd_valid && dev_cfg_o == CFG_RST));

    // A non-key write to the lock register leaves the unlock disarmed
    p_bad_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.lock && wdata != KEY) |=> !armed);

    // A key write arms the unlock
    p_key_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.lock && wdata == KEY) |=> armed);
endmodule

// File: tb/sim_keyed_cfg_regs.sv
// Bench: directed corner cases, then seeded random bus traffic, checked
// against a reference model kept in the bench.
module sim_keyed_cfg_regs;
    localparam int          DW   = 32;
    localparam int          AW   = 4;
    localparam logic [31:0] KEY  = 32'hAA;
    localparam logic [31:0] CRST = 32'h0000_1234;
    localparam logic [31:0] ARST = 32'hC0DE_0001;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rd_valid;
    logic [DW-1:0] dev_cfg_o;
    logic [DW-1:0] aux_cfg_o;
    logic          prot_err;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model
    logic        m_armed = 1'b0;
    logic        m_err = 1'b0;
    logic [31:0] m_cfg = CRST;
    logic [31:0] m_aux = ARST;

    always #10 clk = ~clk;

    keyed_cfg_regs #(.DATA_W(DW), .ADDR_W(AW), .KEY(KEY),
                     .CFG_RST(CRST), .AUX_RST(ARST)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .dev_cfg_o(dev_cfg_o), .aux_cfg_o(aux_cfg_o), .prot_err(prot_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        case (a)
            4'd0:    return {31'd0, m_armed};
            4'd1:    return m_cfg;
            4'd2:    return m_aux;
            4'd3:    return {31'd0, m_err};
            default: return 32'd0;
        endcase
    endfunction

    // Model update for one write, following R2 to R7
    task automatic model_wr(input logic [AW-1:0] a, input logic [31:0] d);
        if (a == 4'd1 || a == 4'd2) begin
            if (m_armed) begin
                if (a == 4'd1) m_cfg = d; else m_aux = d;
            end else begin
                m_err = 1'b1;
            end
        end
        if (a == 4'd3 && d[0]) m_err = 1'b0;
        m_armed = (a == 4'd0) && (d == KEY);
    endtask

    task automatic check_outs(input string req);
        chk(req, dev_cfg_o, m_cfg);
        chk(req, aux_cfg_o, m_aux);
        chk(req, {31'd0, prot_err}, {31'd0, m_err});
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_wr(a, d);
        check_outs(req);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {31'd0, rd_valid}, 32'd1);
        chk(req, rdata, exp_read(a));
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outs("R1");
        chk("R1", {31'd0, rd_valid}, 32'd0);
        bus_rd(4'd0, "R1 lock reads 0");

        // R6 unarmed protected write refused, flag set
        bus_wr(4'd1, 32'hDEAD_BEEF, "R6");
        bus_rd(4'd3, "R6 status bit");
        // R7 writing 0 keeps the flag, writing 1 clears it
        bus_wr(4'd3, 32'h0000_0002, "R7 keep");
        bus_wr(4'd3, 32'h0000_0001, "R7 clear");

        // R2 key arms, R8 read keeps it, R4 write lands
        bus_wr(4'd0, KEY, "R2");
        bus_rd(4'd0, "R2 lock reads 1");
        bus_rd(4'd1, "R8 read while armed");
        bus_rd(4'd0, "R8 still armed");
        bus_wr(4'd1, m_cfg | 32'h0000_0100, "R4 rmw");
        bus_rd(4'd0, "R5 disarmed after use");
        bus_wr(4'd2, 32'h1111_2222, "R6 second write refused");

        // R4 auxiliary register, key repeated twice
        bus_wr(4'd0, KEY, "R2");
        bus_wr(4'd0, KEY, "R2 rearm");
        bus_wr(4'd2, 32'h5A5A_0F0F, "R4 aux");

        // R3 wrong key, also after a good key
        bus_wr(4'd0, 32'h0000_00AB, "R3");
        bus_rd(4'd0, "R3 lock reads 0");
        bus_wr(4'd0, KEY, "R2");
        bus_wr(4'd0, 32'h0000_01AA, "R3 wide value");
        bus_rd(4'd0, "R3 disarmed");

        // R5 unmapped and status writes disarm
        bus_wr(4'd0, KEY, "R2");
        bus_wr(4'd9, 32'hFFFF_FFFF, "R5 unmapped");
        bus_wr(4'd1, 32'h0BAD_0BAD, "R5 refused after unmapped");
        bus_wr(4'd0, KEY, "R2");
        bus_wr(4'd3, 32'h0000_0000, "R5 status write");
        bus_wr(4'd2, 32'h0BAD_0BAD, "R5 refused after status");
        bus_rd(4'd12, "R8 unmapped read");

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            logic [31:0] d;
            op = $urandom % 8;
            d  = $urandom;
            case (op)
                0, 1: bus_wr(4'd0, KEY, "R2 rand");
                2: begin
                    if (d == KEY) d = d ^ 32'h1;
                    bus_wr(4'd0, d, "R3 rand");
                end
                3, 4: bus_wr(4'(1 + ($urandom % 2)), d, "R4 rand");
                5: bus_wr(4'd3, d, "R7 rand");
                6: bus_wr(4'(4 + ($urandom % 12)), d, "R5 rand");
                default: bus_rd(4'($urandom % 16), "R8 rand");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule